// File: doc/BRIEF.md
# Integer Min/Max/Absolute-Difference Unit

This block is a 64-bit integer datapath with a single registered output stage. One operation is issued per start strobe. The operation picks the larger or smaller of two operands, forms their absolute difference, or adds that difference to an accumulator input. A separate bit selects whether the operand ordering is two's-complement or plain magnitude. One comparator produces that ordering and serves every operation.

When the record flag is raised with the strobe, the block also returns a one-hot code that says whether A is below, above or equal to B. The block has no handshake. Inputs are captured on the clock edge where `start_i` is high. The result, the code and a one-cycle valid pulse appear on the next edge, and the result and code then stay put until the next strobe.

Top module: `mmad_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `cmp_o` and `valid_o` are all zero.
- R2: Operation 0 (max) returns A if A is greater than B under the selected ordering, and otherwise returns B.
- R3: Operation 1 (min) returns A if A is less than B under the selected ordering, and otherwise returns B.
- R4: `signed_i`=1 orders the operands as two's-complement numbers, and `signed_i`=0 orders them as unsigned magnitudes. For example, 0x8000_0000_0000_0000 is below 0 when signed and above 0 when unsigned.
- R5: Operation 2 (absolute difference) returns (~A)+B+1 when A<B and (~B)+A+1 otherwise, taken modulo 2^64.
- R6: Operation 3 (accumulate) returns `acc_i` plus the operation 2 value, wrapping modulo 2^64.
- R7: With `record_i`=1, `cmp_o` is 3'b100 for A<B, 3'b010 for A>B and 3'b001 for A==B, under the selected ordering. With `record_i`=0 it is 3'b000.
- R8: `valid_o` is high for exactly the one cycle that follows a clock edge where `start_i` was high.
- R9: `result_o` and `cmp_o` keep their values across every cycle without a strobe.
- R10: With equal operands, operations 2 and 3 add nothing (the difference is 0), and max and min both return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture strobe for the operands and controls |
| op_i | input | 2 | 0 max, 1 min, 2 abs diff, 3 abs diff accumulate |
| signed_i | input | 1 | 1 two's-complement ordering, 0 unsigned |
| record_i | input | 1 | Produce a comparison code |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| acc_i | input | 64 | Accumulator input for operation 3 |
| result_o | output | 64 | Registered result |
| cmp_o | output | 3 | Registered comparison code (less, greater, equal) |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench aims at operand pairs whose order reverses with signedness, such as the most negative value against zero or against all-ones. A design that ignored `signed_i` there would return the wrong maximum and a difference with the wrong sign. Equal operands check that the code reads 3'b001 and not "greater", and that max and min do not both fall through to the same wrong branch. Accumulate cases near 2^64 check that the sum wraps and does not saturate. Idle cycles after each result check that the valid pulse drops and that the result does not drift.

// File: rtl/mmad_pkg.sv
package mmad_pkg;
  typedef enum logic [1:0] {
    OP_MAX  = 2'd0,
    OP_MIN  = 2'd1,
    OP_ABSD = 2'd2,
    OP_ACC  = 2'd3
  } mmad_op_e;

  localparam int unsigned CMP_W = 3;
  localparam logic [CMP_W-1:0] CODE_LT = 3'b100;
  localparam logic [CMP_W-1:0] CODE_GT = 3'b010;
  localparam logic [CMP_W-1:0] CODE_EQ = 3'b001;
endpackage

// File: rtl/mmad_cmp.sv
module mmad_cmp #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  output logic         lt_o,
  output logic         gt_o,
  output logic         eq_o
);
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] a_bias, b_bias;

  // biasing the sign bit turns a signed order into an unsigned one
  always_comb begin
    a_bias = signed_i ? (a_i ^ SIGN_BIT) : a_i;
    b_bias = signed_i ? (b_i ^ SIGN_BIT) : b_i;
    lt_o   = a_bias < b_bias;
    gt_o   = a_bias > b_bias;
    eq_o   = a_i == b_i;
  end
endmodule

// File: rtl/mmad_absdiff.sv
module mmad_absdiff #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         lt_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] acc_sum_o
);
  logic [W-1:0] small_op, large_op;

  always_comb begin
    small_op  = lt_i ? a_i : b_i;
    large_op  = lt_i ? b_i : a_i;
    diff_o    = (~small_op) + large_op + {{(W-1){1'b0}}, 1'b1};
    acc_sum_o = acc_i + diff_o;
  end
endmodule

// File: rtl/mmad_unit.sv
module mmad_unit
  import mmad_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             signed_i,
  input  logic             record_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     acc_i,
  output logic [W-1:0]     result_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic             valid_o
);
  logic             lt, gt, eq;
  logic [W-1:0]     diff, acc_sum;
  logic [W-1:0]     res_d;
  logic [CMP_W-1:0] code_d;

  mmad_cmp #(.W(W)) u_cmp (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i),
    .lt_o(lt), .gt_o(gt), .eq_o(eq)
  );

  mmad_absdiff #(.W(W)) u_absd (
    .a_i(a_i), .b_i(b_i), .lt_i(lt), .acc_i(acc_i),
    .diff_o(diff), .acc_sum_o(acc_sum)
  );

  always_comb begin
    unique case (mmad_op_e'(op_i))
      OP_MAX:  res_d = gt ? a_i : b_i;
      OP_MIN:  res_d = lt ? a_i : b_i;
      OP_ABSD: res_d = diff;
      OP_ACC:  res_d = acc_sum;
      default: res_d = '0;
    endcase
    if (!record_i)  code_d = '0;
    else if (lt)    code_d = CODE_LT;
    else if (gt)    code_d = CODE_GT;
    else            code_d = eq ? CODE_EQ : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      cmp_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        result_o <= res_d;
        cmp_o    <= code_d;
      end
    end
  end
endmodule

// File: rtl/mmad_checker.sv
module mmad_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic         record_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic [2:0]   cmp_o,
  input logic         valid_o
);
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && cmp_o == '0 && !valid_o));

  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(cmp_o)));

  assert_code_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmp_o));

  assert_code_eq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && record_i && a_i == b_i) |=> cmp_o == 3'b001);

  assert_minmax_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[1]) |=> (result_o == $past(a_i) || result_o == $past(b_i)));

  assert_absd_eq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'd2 && a_i == b_i) |=> result_o == '0);
endmodule

bind mmad_unit mmad_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .record_i(record_i), .a_i(a_i), .b_i(b_i), .result_o(result_o),
  .cmp_o(cmp_o), .valid_o(valid_o)
);

// File: tb/tb_mmad_unit.sv
module tb_mmad_unit;
  localparam int W = 64;
  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  logic         clk = 0;
  logic         rst_ni = 0;
  logic         start_i = 0;
  logic [1:0]   op_i = 0;
  logic         signed_i = 0;
  logic         record_i = 0;
  logic [W-1:0] a_i = 0, b_i = 0, acc_i = 0;
  logic [W-1:0] result_o;
  logic [2:0]   cmp_o;
  logic         valid_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmad_unit #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .signed_i(signed_i), .record_i(record_i), .a_i(a_i), .b_i(b_i),
    .acc_i(acc_i), .result_o(result_o), .cmp_o(cmp_o), .valid_o(valid_o)
  );

  function automatic bit ref_lt(bit s, logic [63:0] a, logic [63:0] b);
    return s ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  function automatic logic [63:0] ref_res(logic [1:0] op, bit s,
      logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    bit l = ref_lt(s, a, b);
    bit g = ref_lt(s, b, a);
    logic [63:0] d = l ? (b - a) : (a - b);
    case (op)
      2'd0: return g ? a : b;
      2'd1: return l ? a : b;
      2'd2: return d;
      default: return acc + d;
    endcase
  endfunction

  function automatic logic [2:0] ref_code(bit r, bit s, logic [63:0] a, logic [63:0] b);
    if (!r) return 3'b000;
    if (ref_lt(s, a, b)) return 3'b100;
    if (ref_lt(s, b, a)) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(logic [1:0] op, bit s, bit r,
      logic [63:0] a, logic [63:0] b, logic [63:0] acc, bit idle);
    logic [63:0] er = ref_res(op, s, a, b, acc);
    logic [2:0]  ec = ref_code(r, s, a, b);
    @(negedge clk);
    op_i = op; signed_i = s; record_i = r; a_i = a; b_i = b; acc_i = acc;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(op_tag(op), result_o, er);
    chk("R7", {61'd0, cmp_o}, {61'd0, ec});
    chk("R8", {63'd0, valid_o}, 64'd1);
    if (idle) begin
      a_i = ~a; b_i = ~b; acc_i = ~acc; record_i = ~r;
      @(negedge clk);
      chk("R8", {63'd0, valid_o}, 64'd0);
      chk("R9", result_o, er);
      chk("R9", {61'd0, cmp_o}, {61'd0, ec});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", result_o, 64'd0);
    chk("R1", {61'd0, cmp_o}, 64'd0);
    chk("R1", {63'd0, valid_o}, 64'd0);
    rst_ni = 1;

    // R4: order flips with signedness
    run_op(2'd0, 1, 1, MINS, 64'd0, 0, 1);
    run_op(2'd0, 0, 1, MINS, 64'd0, 0, 1);
    run_op(2'd1, 1, 1, ONES, 64'd1, 0, 1);
    run_op(2'd1, 0, 1, ONES, 64'd1, 0, 1);
    run_op(2'd2, 1, 1, MINS, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1);
    run_op(2'd2, 0, 1, 64'd3, ONES, 0, 1);
    // R10: equal operands
    for (int op = 0; op < 4; op++)
      run_op(2'(op), op[0], 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'd77, 1);
    // R6: wrap
    run_op(2'd3, 0, 0, 64'd0, 64'd10, ONES - 64'd3, 1);
    run_op(2'd3, 1, 1, MINS, 64'd1, 64'd5, 1);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [63:0] c = {$urandom, $urandom};
      if (($urandom % 8) == 0) b = a;
      run_op(2'($urandom), 1'($urandom), 1'($urandom), a, b, c, ($urandom % 2) == 0);
    end

    // back-to-back strobes: valid stays high
    @(negedge clk);
    op_i = 2'd0; signed_i = 0; record_i = 0; a_i = 64'd9; b_i = 64'd4; start_i = 1;
    @(negedge clk);
    chk("R8", {63'd0, valid_o}, 64'd1);
    a_i = 64'd2;
    @(negedge clk);
    start_i = 0;
    chk("R8", {63'd0, valid_o}, 64'd1);
    chk("R2", result_o, 64'd4);
    @(negedge clk);
    chk("R8", {63'd0, valid_o}, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule